// File: doc/BRIEF.md
# Burst Harvest Mode Sequencer

This block sequences a burst-mode switched-capacitor energy harvester. While the source charges a buffer capacitor, the block keeps the charge-pump domain power gated and every transfer switch open. When the source voltage climbs past a high comparator threshold, it opens a transfer burst. The burst starts with a startup phase. In that phase the pump runs from the battery supply on the startup clock, and the conversion-ratio controller gets a one-cycle initialise pulse. After a fixed number of settle cycles the block moves to the operation phase. There it selects the regulated low supply and the operation clock.

The burst ends as soon as the source voltage drops past a low comparator threshold, and the block goes back to harvesting. The gap between the two thresholds gives hysteresis. Both comparator flags come from an asynchronous analog domain, so each passes through a two-flop synchroniser first. The low-threshold flag has priority over the high-threshold flag. The settle count is a parameter, `SETTLE_CYCLES`, with a default of 64. All control pins are plain level signals, with no handshake.

Top module: `burst_harvest_seq`

## Requirements
- R1: While reset is asserted and right after it, the block is harvesting: `pump_en`, `sw_en`, `supply_sel`, `clk_sel` and `ratio_init` are all 0.
- R2: While harvesting, all three bits of `sw_en` are 0 and `pump_en` is 0 (pump domain gated).
- R3: When `src_above_hi` is seen high (and `src_below_lo` low) at a clock edge, startup begins at the third edge counted from that one, because of the two synchroniser flops. In startup, `pump_en`=1 and `sw_en`=3'b111.
- R4: Startup lasts exactly `SETTLE_CYCLES` clock cycles if it is not aborted, and then operation begins.
- R5: `supply_sel` is 0 (battery) during harvest and startup, and 1 (regulated low supply) during operation.
- R6: `clk_sel` is 0 (startup clock) and rises to 1 (operation clock) only at the startup-to-operation edge. It stays constant within a phase, and it returns to 0 only when the pump domain is gated again.
- R7: `ratio_init` is high for exactly the first cycle of each startup phase, and low at all other times.
- R8: When `src_below_lo` is seen high during startup or operation, the block is back in harvest (all outputs 0) at the third edge counted from that sample.
- R9: When both flags are high, the low flag wins. The block does not leave harvest, and it leaves startup or operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_above_hi | input | 1 | Comparator flag: source above high threshold (async) |
| src_below_lo | input | 1 | Comparator flag: source below low threshold (async) |
| pump_en | output | 1 | 1 = pump power domain on (transfer mode) |
| sw_en | output | 3 | Transfer-switch enables, all equal |
| supply_sel | output | 1 | 0 = battery supply, 1 = regulated low supply |
| clk_sel | output | 1 | Glitch-free mux select: 0 = startup clock, 1 = operation clock |
| ratio_init | output | 1 | One-cycle conversion-ratio initialise pulse |

## Verification
The bench steps a behavioural reference of the harvest/startup/operation sequence and compares every output on every clock. The stimulus covers a held high flag and a single-cycle high pulse, which test whether the synchroniser samples rather than filters. It also covers a full undisturbed startup, which pins the exact settle length, and a low flag during startup, which shows an abort apart from a normal exit. Both flags high are applied in harvest and in operation, which exposes the wrong priority in either phase.

// File: rtl/hts_pkg.sv
package hts_pkg;
  typedef enum logic [1:0] {
    PH_HARVEST = 2'b00,
    PH_STARTUP = 2'b01,
    PH_OPERATE = 2'b10
  } phase_e;

  localparam int NUM_SW = 3;
endpackage

// File: rtl/hts_sync.sv
module hts_sync #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic meta_q, stable_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[b];
        stable_q <= meta_q;
      end
    end
    assign sync_out[b] = stable_q;
  end
endmodule

// File: rtl/hts_settle_timer.sv
module hts_settle_timer #(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (!run)  cnt_q <= '0;
    else if (!done) cnt_q <= cnt_q + 1'b1;
  end

  AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R4
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0); // R4
endmodule

// File: rtl/hts_phase_fsm.sv
module hts_phase_fsm
  import hts_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hi_seen,
  input  logic   lo_seen,
  input  logic   settle_done,
  output phase_e phase,
  output phase_e phase_nxt
);
  phase_e phase_q;

  always_comb begin
    phase_nxt = phase_q;
    unique case (phase_q)
      PH_HARVEST: if (!lo_seen && hi_seen) phase_nxt = PH_STARTUP;
      PH_STARTUP: begin
        if (lo_seen)          phase_nxt = PH_HARVEST;
        else if (settle_done) phase_nxt = PH_OPERATE;
      end
      PH_OPERATE: if (lo_seen) phase_nxt = PH_HARVEST;
      default:    phase_nxt = PH_HARVEST;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_HARVEST;
    else        phase_q <= phase_nxt;
  end

  assign phase = phase_q;

  AST_LOW_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_seen && phase_q != PH_HARVEST) |=> phase_q == PH_HARVEST); // R8
  AST_LOW_BLOCKS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_seen && phase_q == PH_HARVEST) |=> phase_q == PH_HARVEST); // R9
  AST_OPERATE_VIA_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OPERATE && $past(phase_q) != PH_OPERATE) |-> $past(phase_q) == PH_STARTUP); // R4
endmodule

// File: rtl/hts_drive.sv
module hts_drive
  import hts_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  phase_e            phase_nxt,
  output logic              pump_en,
  output logic [NUM_SW-1:0] sw_en,
  output logic              supply_sel,
  output logic              clk_sel,
  output logic              ratio_init
);
  logic on_nxt;
  assign on_nxt = (phase_nxt != PH_HARVEST);

  for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_en[s] <= 1'b0;
      else        sw_en[s] <= on_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pump_en    <= 1'b0;
      supply_sel <= 1'b0;
      clk_sel    <= 1'b0;
      ratio_init <= 1'b0;
    end else begin
      pump_en    <= on_nxt;
      supply_sel <= (phase_nxt == PH_OPERATE);
      clk_sel    <= (phase_nxt == PH_OPERATE);
      ratio_init <= (phase == PH_HARVEST) && (phase_nxt == PH_STARTUP);
    end
  end

  AST_CLKSEL_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_sel) |-> $past(phase) == PH_STARTUP); // R6
  AST_CLKSEL_FALL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_sel) |-> !pump_en); // R6
  AST_RATIO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_init |=> !ratio_init); // R7
endmodule

// File: rtl/burst_harvest_seq.sv
module burst_harvest_seq
  import hts_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_above_hi,
  input  logic       src_below_lo,
  output logic       pump_en,
  output logic [2:0] sw_en,
  output logic       supply_sel,
  output logic       clk_sel,
  output logic       ratio_init
);
  logic [1:0] flags_sync;
  logic       settle_done;
  phase_e     phase, phase_nxt;

  hts_sync #(.WIDTH(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({src_below_lo, src_above_hi}),
    .sync_out (flags_sync)
  );

  hts_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (phase == PH_STARTUP),
    .done  (settle_done)
  );

  hts_phase_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .hi_seen     (flags_sync[0]),
    .lo_seen     (flags_sync[1]),
    .settle_done (settle_done),
    .phase       (phase),
    .phase_nxt   (phase_nxt)
  );

  hts_drive u_drive (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .phase_nxt  (phase_nxt),
    .pump_en    (pump_en),
    .sw_en      (sw_en),
    .supply_sel (supply_sel),
    .clk_sel    (clk_sel),
    .ratio_init (ratio_init)
  );

  AST_HARVEST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pump_en |-> (sw_en == 3'b000 && !supply_sel && !clk_sel)); // R2
  AST_STARTUP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pump_en) |-> ratio_init); // R7
  AST_BATTERY_IN_STARTUP: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_init |-> (!supply_sel && sw_en == 3'b111)); // R5
endmodule

// File: tb/burst_harvest_seq_test.sv
module burst_harvest_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 64;
  localparam int WATCHDOG = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hi = 1'b0;
  logic lo = 1'b0;
  logic pump_en, supply_sel, clk_sel, ratio_init;
  logic [2:0] sw_en;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done_flag = 0;

  // reference: 0 harvest, 1 startup, 2 operation
  int m_phase = 0;
  int m_cnt = 0;
  int m_pulse = 0;
  int hi_d1 = 0, hi_d2 = 0, lo_d1 = 0, lo_d2 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_harvest_seq #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .src_above_hi(hi), .src_below_lo(lo),
    .pump_en(pump_en), .sw_en(sw_en), .supply_sel(supply_sel),
    .clk_sel(clk_sel), .ratio_init(ratio_init)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int hs, ls;
    cycles++;
    if (!rst_n) begin
      m_phase = 0; m_cnt = 0; m_pulse = 0;
      hi_d1 = 0; hi_d2 = 0; lo_d1 = 0; lo_d2 = 0;
    end else begin
      hs = hi_d2; ls = lo_d2;
      hi_d2 = hi_d1; lo_d2 = lo_d1;
      hi_d1 = int'(hi); lo_d1 = int'(lo);
      m_pulse = 0;
      case (m_phase)
        0: if (ls == 0 && hs == 1) begin m_phase = 1; m_cnt = 0; m_pulse = 1; end
        1: begin
          if (ls == 1) m_phase = 0;
          else if (m_cnt == SETTLE - 1) m_phase = 2;
          else m_cnt++;
        end
        default: if (ls == 1) m_phase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (!done_flag) begin
      chk("R3 pump_en", int'(pump_en), (m_phase != 0) ? 1 : 0);
      chk("R2 sw_en", int'(sw_en), (m_phase != 0) ? 7 : 0);
      chk("R5 supply_sel", int'(supply_sel), (m_phase == 2) ? 1 : 0);
      chk("R6 clk_sel", int'(clk_sel), (m_phase == 2) ? 1 : 0);
      chk("R7 ratio_init", int'(ratio_init), m_pulse);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    tick(3);
    chk("R1 reset pump_en", int'(pump_en), 0);
    chk("R1 reset sw_en", int'(sw_en), 0);
    rst_n = 1'b1;
    tick(4);
    chk("R1 idle after reset", int'(pump_en), 0);

    // R3: held high flag, entry on third edge
    hi = 1'b1;
    tick(2);
    chk("R3 not yet at 2nd edge", int'(pump_en), 0);
    tick(1);
    chk("R3 startup at 3rd edge", int'(pump_en), 1);
    chk("R7 pulse first startup cycle", int'(ratio_init), 1);
    hi = 1'b0;
    tick(1);
    chk("R7 pulse gone", int'(ratio_init), 0);
    // R4: startup length
    tick(SETTLE - 2);
    chk("R4 still startup", int'(supply_sel), 0);
    tick(1);
    chk("R4 operation after settle", int'(supply_sel), 1);
    chk("R6 clk_sel at operation", int'(clk_sel), 1);
    tick(20);

    // R8: exit from operation
    lo = 1'b1;
    tick(3);
    chk("R8 harvest after low", int'(pump_en), 0);
    chk("R6 clk_sel cleared", int'(clk_sel), 0);
    // R9: both flags in harvest
    hi = 1'b1;
    tick(10);
    chk("R9 low wins in harvest", int'(pump_en), 0);
    lo = 1'b0;
    tick(3);
    chk("R3 entry once low clears", int'(pump_en), 1);
    hi = 1'b0;
    // R8: abort during startup
    tick(10);
    lo = 1'b1;
    tick(1);
    lo = 1'b0;
    tick(2);
    chk("R8 startup aborted", int'(pump_en), 0);
    chk("R6 no clk change on abort", int'(clk_sel), 0);
    tick(5);

    // single-cycle high pulse still captured
    hi = 1'b1;
    tick(1);
    hi = 1'b0;
    tick(2);
    chk("R3 one-cycle pulse enters", int'(pump_en), 1);
    tick(SETTLE + 5);
    chk("R5 operation supply", int'(supply_sel), 1);
    // R9: both flags in operation
    hi = 1'b1; lo = 1'b1;
    tick(3);
    chk("R9 low wins in operation", int'(pump_en), 0);
    hi = 1'b0; lo = 1'b0;
    tick(10);

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    wait (cycles >= WATCHDOG);
    if (!done_flag) begin
      done_flag = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=<%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule